// File: doc/BRIEF.md
# Capability Tag Cache Controller

This block tracks a one-bit validity tag for every 16-byte granule of physical memory. A set tag means the granule holds a valid capability. The tags do not sit in the main data path. They live in a reserved tag region of main memory, and a small direct-mapped, write-back side cache next to the L2 cache holds the ones in recent use. Each cache line is 64 bytes, so it carries 512 tags and covers 8 KB of data.

The L2 side sends one request at a time through a ready/valid handshake. A load returns the tag of the addressed granule. An ordinary data store clears that granule's tag. A capability store writes the tag that comes with it, but only if the address is 16-byte aligned. A misaligned capability store is rejected with a fault. On a miss the block writes the victim line back if it is dirty, then fetches the missing line from the tag region. It applies the pending operation in the same cycle that the fill data arrives. While the miss is being handled the block holds off new requests. The tag update and the response go out together in one cycle, so the requester never sees a completed store together with a stale tag.

Top module: `capability_tag_cache`

## Requirements
- R1: A load (req_op 2'b00) returns in rsp_tag the tag bit of the 16-byte granule that contains req_addr. Address bits [3:0] have no effect on the result.
- R2: The tag byte for a physical address pa sits at TAG_BASE + (pa >> 7). Bit pa[6:4] of that byte is the granule's tag. The line fetched or written back is the 64-byte block at TAG_BASE + ((pa >> 13) << 6). Inside the 512-bit line word, byte k occupies bits [8k+7:8k], so the granule tag is line bit pa[12:4].
- R3: An aligned capability store (req_op 2'b10, req_addr[3:0] == 0) sets the granule tag to req_cap_tag. The same response reports that new value in rsp_tag.
- R4: A capability store with req_addr[3:0] != 0 responds with rsp_fault = 1 in the cycle after acceptance. It changes no tag and starts no memory request.
- R5: A data store (req_op 2'b01) to any byte of a granule clears that granule's tag and reports 0 in rsp_tag.
- R6: After reset, req_ready is 1 and busy, rsp_valid and mem_req_valid are 0. Every cache line is invalid, so the first access to each line issues exactly one memory read.
- R7: A request that hits responds in the cycle after acceptance and issues no memory request.
- R8: A miss that replaces a dirty line first writes the victim's 512 bits to the victim's own tag-region address, then reads the new line. A clean victim is not written back.
- R9: From the acceptance of a miss until its response, busy is 1 and req_ready is 0. Outside that window busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 load, 01 data store, 10 capability store |
| req_addr | input | PA_W | Physical byte address |
| req_cap_tag | input | 1 | Tag written by a capability store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_tag | output | 1 | Tag read, or tag just written |
| rsp_fault | output | 1 | Misaligned capability store rejected |
| busy | output | 1 | Miss or writeback in progress |
| mem_req_valid | output | 1 | Tag-region memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write-back, 0 line read |
| mem_req_addr | output | PA_W | 64-byte aligned tag-region address |
| mem_req_wdata | output | 512 | Line written back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 512 | Line read from the tag region |

## Verification
Directed sequences after reset first sweep one line per cache index to expose cold misses. They then hit the same granule at different byte offsets, which separates granule selection from byte selection. Stores followed by loads separate the set and clear paths from the fault path. A pair of addresses that share an index but differ in cache tag forces dirty and then clean evictions, so write-back contents and addresses can be compared against the refetched tags. A seeded random mix of loads, data stores and aligned and misaligned capability stores over a small address window then exercises hits, conflict misses and memory stalls together. Each result is checked against a granule-level reference that starts from the known memory pattern.

// File: rtl/tagc_pkg.sv
// Shared constants and types for the capability tag cache.
// Assumes a fixed 16-byte granule and a 64-byte tag cache line.
package tagc_pkg;
    localparam int GRAN_SHIFT = 4;                       // 16-byte granule
    localparam int LINE_BYTES = 64;                      // tag cache line
    localparam int LINE_BITS  = LINE_BYTES * 8;          // tags per line
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);      // 6
    localparam int BSEL_W     = $clog2(LINE_BITS);       // 9
    localparam int LINE_SHIFT = GRAN_SHIFT + BSEL_W;     // 13: data bytes per line

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_DSTORE = 2'b01,
        OP_CSTORE = 2'b10,
        OP_RSVD   = 2'b11
    } tag_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_WAIT
    } tagc_state_e;
endpackage

// File: rtl/tagc_addr_map.sv
// Address mapping from a physical granule address into the tag cache and
// the tag region of memory. Also rebuilds a victim line's memory address.
// Assumes TAG_BASE is 64-byte aligned.
module tagc_addr_map
    import tagc_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int IDX_W = 4,
    parameter int CT_W  = PA_W - LINE_SHIFT - IDX_W,
    parameter logic [PA_W-1:0] TAG_BASE = '0
) (
    input  logic [PA_W-1:GRAN_SHIFT] gran_addr,
    input  logic [CT_W-1:0]          vict_ctag,
    output logic [IDX_W-1:0]         idx,
    output logic [CT_W-1:0]          ctag,
    output logic [BSEL_W-1:0]        bsel,
    output logic [PA_W-1:0]          fill_addr,
    output logic [PA_W-1:0]          vict_addr
);
    localparam int PAD_W = LINE_SHIFT - LINE_OFF_W;

    // split the granule address into line index, cache tag and bit select
    assign bsel = gran_addr[LINE_SHIFT-1:GRAN_SHIFT];
    assign idx  = gran_addr[LINE_SHIFT+IDX_W-1:LINE_SHIFT];
    assign ctag = gran_addr[PA_W-1:LINE_SHIFT+IDX_W];

    // tag-region line address of the requested line and of the victim
    assign fill_addr = TAG_BASE + {{PAD_W{1'b0}}, gran_addr[PA_W-1:LINE_SHIFT], {LINE_OFF_W{1'b0}}};
    assign vict_addr = TAG_BASE + {{PAD_W{1'b0}}, vict_ctag, idx, {LINE_OFF_W{1'b0}}};
endmodule

// File: rtl/tagc_array.sv
// Direct-mapped tag line storage with valid and dirty bits per line.
// One combinational read port and one write port; a write marks the line valid.
// Assumes NUM_LINES is a power of two of at least 2.
module tagc_array #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES),
    parameter int CT_W      = 15,
    parameter int LB        = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [CT_W-1:0]  rd_ctag,
    output logic [LB-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CT_W-1:0]  wr_ctag,
    input  logic [LB-1:0]    wr_data,
    input  logic             wr_dirty
);
    logic            valid_q [NUM_LINES];
    logic            dirty_q [NUM_LINES];
    logic [CT_W-1:0] ctag_q  [NUM_LINES];
    logic [LB-1:0]   data_q  [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // per-line state: cleared to invalid by reset, set on a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= wr_dirty;
            end
        end

        // per-line payload: cache tag and 512 granule tags
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                ctag_q[g] <= wr_ctag;
                data_q[g] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_ctag  = ctag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/tagc_update.sv
// Applies one request to a tag line: reads the selected bit and produces
// the line with that bit rewritten. A load leaves the line unchanged.
module tagc_update
    import tagc_pkg::*;
#(
    parameter int LB = LINE_BITS,
    parameter int BW = $clog2(LB)
) (
    input  logic [LB-1:0] line_in,
    input  logic [BW-1:0] bsel,
    input  tag_op_e       op,
    input  logic          cap_tag,
    output logic [LB-1:0] line_out,
    output logic          tag_out,
    output logic          modifies
);
    // choose the new tag bit per operation and splice it into the line
    always_comb begin
        unique case (op)
            OP_DSTORE: tag_out = 1'b0;
            OP_CSTORE: tag_out = cap_tag;
            default:   tag_out = line_in[bsel];
        endcase
        modifies       = (op == OP_DSTORE) || (op == OP_CSTORE);
        line_out       = line_in;
        line_out[bsel] = tag_out;
    end
endmodule

// File: rtl/capability_tag_cache.sv
// Capability tag cache controller. Looks up the granule tag for each L2-side
// request, handles misses with an optional dirty write-back followed by a line
// fill, and rejects misaligned capability stores. One request is in flight at
// a time. Assumes memory write requests complete on acceptance.
module capability_tag_cache
    import tagc_pkg::*;
#(
    parameter int PA_W      = 32,
    parameter int NUM_LINES = 16,
    parameter logic [PA_W-1:0] TAG_BASE = 32'h8000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [PA_W-1:0]      req_addr,
    input  logic                 req_cap_tag,
    output logic                 rsp_valid,
    output logic                 rsp_tag,
    output logic                 rsp_fault,
    output logic                 busy,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [PA_W-1:0]      mem_req_addr,
    output logic [LINE_BITS-1:0] mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [LINE_BITS-1:0] mem_rsp_rdata
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int CT_W  = PA_W - LINE_SHIFT - IDX_W;

    tagc_state_e          state_q;
    logic [PA_W-1:0]      cap_addr_q;
    tag_op_e              cap_op_q;
    logic                 cap_tag_q;
    logic                 rsp_valid_q, rsp_tag_q, rsp_fault_q;

    logic                 in_idle, accept, misalign, hit, hit_store, fill_done, go_miss;
    logic [PA_W-1:0]      cur_addr;
    tag_op_e              cur_op;
    logic                 cur_cap;
    logic [IDX_W-1:0]     idx;
    logic [CT_W-1:0]      ctag, rd_ctag;
    logic [BSEL_W-1:0]    bsel;
    logic [PA_W-1:0]      fill_addr, vict_addr;
    logic                 rd_valid, rd_dirty;
    logic [LINE_BITS-1:0] rd_data, src_line, new_line;
    logic                 tag_out, modifies, wr_en;

    // request selection: live inputs when idle, captured request during a miss
    assign in_idle  = (state_q == ST_IDLE);
    assign cur_addr = in_idle ? req_addr : cap_addr_q;
    assign cur_op   = in_idle ? tag_op_e'(req_op) : cap_op_q;
    assign cur_cap  = in_idle ? req_cap_tag : cap_tag_q;

    tagc_addr_map #(.PA_W(PA_W), .IDX_W(IDX_W), .CT_W(CT_W), .TAG_BASE(TAG_BASE)) u_map (
        .gran_addr (cur_addr[PA_W-1:GRAN_SHIFT]),
        .vict_ctag (rd_ctag),
        .idx       (idx),
        .ctag      (ctag),
        .bsel      (bsel),
        .fill_addr (fill_addr),
        .vict_addr (vict_addr)
    );

    tagc_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .CT_W(CT_W), .LB(LINE_BITS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_ctag  (rd_ctag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_ctag  (ctag),
        .wr_data  (new_line),
        .wr_dirty (modifies)
    );

    // the fill data replaces the array line in the cycle it arrives
    assign src_line = (state_q == ST_WAIT) ? mem_rsp_rdata : rd_data;

    tagc_update #(.LB(LINE_BITS), .BW(BSEL_W)) u_upd (
        .line_in  (src_line),
        .bsel     (bsel),
        .op       (cur_op),
        .cap_tag  (cur_cap),
        .line_out (new_line),
        .tag_out  (tag_out),
        .modifies (modifies)
    );

    // request classification and array write enable
    assign accept    = req_valid && in_idle;
    assign misalign  = (cur_op == OP_CSTORE) && (cur_addr[GRAN_SHIFT-1:0] != '0);
    assign hit       = rd_valid && (rd_ctag == ctag);
    assign hit_store = accept && !misalign && hit && modifies;
    assign fill_done = (state_q == ST_WAIT) && mem_rsp_valid;
    assign go_miss   = accept && !misalign && !hit;
    assign wr_en     = hit_store || fill_done;

    // miss sequencing: optional write-back, line read, wait for the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cap_addr_q <= '0;
            cap_op_q   <= OP_LOAD;
            cap_tag_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go_miss) begin
                    cap_addr_q <= req_addr;
                    cap_op_q   <= tag_op_e'(req_op);
                    cap_tag_q  <= req_cap_tag;
                    state_q    <= (rd_valid && rd_dirty) ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_req_ready) state_q <= ST_FILL;
                ST_FILL:  if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // response register: tag and fault leave together with the update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_tag_q   <= 1'b0;
            rsp_fault_q <= 1'b0;
        end else begin
            rsp_valid_q <= (accept && (misalign || hit)) || fill_done;
            rsp_fault_q <= accept && misalign;
            rsp_tag_q   <= (accept && misalign) ? 1'b0 : tag_out;
        end
    end

    assign req_ready     = in_idle;
    assign busy          = !in_idle;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_tag       = rsp_tag_q;
    assign rsp_fault     = rsp_fault_q;
    assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign mem_req_write = (state_q == ST_WBACK);
    assign mem_req_addr  = (state_q == ST_WBACK) ? vict_addr : fill_addr;
    assign mem_req_wdata = rd_data;
endmodule

// File: rtl/tagc_checker.sv
// Protocol and sequencing checks for the capability tag cache, bound to the top.
module tagc_checker #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_op,
    input logic [PA_W-1:0] req_addr,
    input logic            busy,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_write,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    logic bad_cap;
    assign bad_cap = req_valid && req_ready && (req_op == 2'b10) && (req_addr[3:0] != 4'd0);

    assert_fault_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cap |=> (rsp_valid && rsp_fault));

    assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cap |=> (!busy && !mem_req_valid));

    assert_line_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[5:0] == 6'd0));

    assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=> (mem_req_valid && !mem_req_write));

    assert_fill_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid && mem_rsp_valid) |=> (rsp_valid && !busy));

    assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    assert_rsp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid)));
endmodule

bind capability_tag_cache tagc_checker #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/capability_tag_cache_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic
// against a granule-level reference and a stalling memory model.
module capability_tag_cache_tb;
    localparam logic [31:0] TB_BASE = 32'h8000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_ready, req_cap_tag = 1'b0;
    logic [1:0]   req_op = 2'b00;
    logic [31:0]  req_addr = '0;
    logic         rsp_valid, rsp_tag, rsp_fault, busy;
    logic         mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
    logic [31:0]  mem_req_addr;
    logic [511:0] mem_req_wdata, mem_rsp_rdata;

    int n_tests = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd = '0, last_wr = '0;
    logic [511:0] mem_q [logic [31:0]];
    bit ref_q [logic [31:0]];

    capability_tag_cache #(.PA_W(32), .NUM_LINES(16), .TAG_BASE(TB_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_cap_tag(req_cap_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_fault(rsp_fault), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    initial forever #4 clk = ~clk;   // 125 MHz

    // initial tag-region contents, a fixed function of the line address
    function automatic logic [511:0] def_line(input logic [31:0] a);
        logic [511:0] l;
        for (int k = 0; k < 16; k++)
            l[k*32 +: 32] = (a * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_1234;
        return l;
    endfunction

    function automatic logic [511:0] mem_line(input logic [31:0] a);
        if (mem_q.exists(a)) return mem_q[a];
        return def_line(a);
    endfunction

    function automatic logic [31:0] line_of(input logic [31:0] pa);
        return TB_BASE + ((pa >> 13) << 6);
    endfunction

    function automatic logic exp_tag(input logic [31:0] pa);
        logic [511:0] l;
        if (ref_q.exists(pa >> 4)) return ref_q[pa >> 4];
        l = def_line(line_of(pa));
        return l[pa[12:4]];
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // memory model: random ready, read data two negedges after acceptance
    initial begin
        int dly;
        bit pend;
        logic [31:0] pend_addr;
        pend = 0; dly = 0; pend_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend) begin
                dly--;
                if (dly == 0) begin
                    pend = 0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mem_line(pend_addr);
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem_q[mem_req_addr] = mem_req_wdata;
                    wr_cnt++;
                    last_wr = mem_req_addr;
                end else begin
                    rd_cnt++;
                    last_rd = mem_req_addr;
                    pend = 1; pend_addr = mem_req_addr; dly = 2;
                end
            end
        end
    end

    // one request: called at a negedge, returns at the negedge showing rsp_valid
    task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input logic ct,
                          output logic t, output logic f, output int lat, output logic busy_ok);
        req_op = op; req_addr = addr; req_cap_tag = ct; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ok = 1'b1;
        while (!rsp_valid) begin
            if (!busy || req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (busy || !req_ready) busy_ok = 1'b0;
        t = rsp_tag; f = rsp_fault;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R9 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic t, f, bok, et;
        int lat, r0, w0;
        logic [31:0] a, b;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        chk("R6", req_ready, 1, "req_ready after reset");
        chk("R6", busy, 0, "busy after reset");
        chk("R6", rsp_valid, 0, "rsp_valid after reset");
        chk("R6", mem_req_valid, 0, "mem_req_valid after reset");

        // R6: cold misses, one read per line, on every index
        for (int i = 0; i < 16; i++) begin
            a = 32'(i) << 13;
            r0 = rd_cnt;
            do_req(2'b00, a, 1'b0, t, f, lat, bok);
            chk("R6", rd_cnt - r0, 1, "reads on first access");
            chk("R1", t, exp_tag(a), "cold load tag");
            chk("R9", bok, 1, "busy/ready during miss");
        end

        // R2: mapping of the fill address and tag bit
        a = 32'h0002_2340;
        r0 = rd_cnt;
        do_req(2'b00, a, 1'b0, t, f, lat, bok);
        chk("R2", last_rd, line_of(a), "fill address");
        chk("R2", rd_cnt - r0, 1, "fill count");
        chk("R2", t, exp_tag(a), "mapped tag bit");

        // R7: hit latency and no traffic; R1: byte offset ignored
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(2'b00, a + 32'd7, 1'b0, t, f, lat, bok);
        chk("R7", lat, 1, "hit latency");
        chk("R7", (rd_cnt - r0) + (wr_cnt - w0), 0, "hit memory traffic");
        chk("R1", t, exp_tag(a), "offset within granule");

        // R3: aligned capability store sets, response carries it
        do_req(2'b10, a, 1'b1, t, f, lat, bok);
        ref_q[a >> 4] = 1'b1;
        chk("R3", {f, t}, 2'b01, "cap store response");
        do_req(2'b00, a + 32'd15, 1'b0, t, f, lat, bok);
        chk("R3", t, 1, "tag after cap store");

        // R5: partial data store clears
        do_req(2'b01, a + 32'd4, 1'b0, t, f, lat, bok);
        ref_q[a >> 4] = 1'b0;
        chk("R5", t, 0, "data store response tag");
        do_req(2'b00, a, 1'b0, t, f, lat, bok);
        chk("R5", t, 0, "tag after data store");

        // R4: misaligned cap store faults and changes nothing
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(2'b10, a + 32'd8, 1'b1, t, f, lat, bok);
        chk("R4", f, 1, "fault on misaligned cap store");
        chk("R4", lat, 1, "fault latency");
        do_req(2'b00, a, 1'b0, t, f, lat, bok);
        chk("R4", t, 0, "tag unchanged after fault");
        b = 32'h0006_6004;
        do_req(2'b10, b, 1'b1, t, f, lat, bok);
        chk("R4", f, 1, "fault on uncached line");
        chk("R4", (rd_cnt - r0) + (wr_cnt - w0), 0, "no memory traffic on fault");

        // R8: dirty eviction then clean eviction
        do_req(2'b10, a, 1'b1, t, f, lat, bok);
        ref_q[a >> 4] = 1'b1;
        b = a + 32'h0002_0000;
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(2'b00, b, 1'b0, t, f, lat, bok);
        chk("R8", wr_cnt - w0, 1, "dirty victim written back");
        chk("R8", last_wr, line_of(a), "write-back address");
        chk("R8", last_rd, line_of(b), "fill after write-back");
        chk("R8", t, exp_tag(b), "tag of new line");
        chk("R9", bok, 1, "busy during eviction");
        w0 = wr_cnt;
        do_req(2'b00, a, 1'b0, t, f, lat, bok);
        chk("R8", wr_cnt - w0, 0, "clean victim not written");
        chk("R8", t, 1, "tag survives write-back");

        // random mix over a small window to force conflicts
        for (int n = 0; n < 2000; n++) begin
            int r;
            logic [1:0] op;
            logic ct;
            r = $urandom % 10;
            a = $urandom & 32'h0007_FFFF;
            ct = $urandom % 2;
            if (r < 4) op = 2'b00;
            else if (r < 7) op = 2'b01;
            else begin
                op = 2'b10;
                if ($urandom % 5 != 0) a[3:0] = 4'd0;
                else a[3:0] = 4'(1 + $urandom % 15);
            end
            do_req(op, a, ct, t, f, lat, bok);
            if (op == 2'b10 && a[3:0] != 4'd0) begin
                chk("R4", f, 1, "random misaligned fault");
            end else if (op == 2'b10) begin
                chk("R3", {f, t}, {1'b0, ct}, "random cap store");
                ref_q[a >> 4] = ct;
            end else if (op == 2'b01) begin
                chk("R5", {f, t}, 2'b00, "random data store");
                ref_q[a >> 4] = 1'b0;
            end else begin
                et = exp_tag(a);
                chk("R1", {f, t}, {1'b0, et}, "random load");
            end
            chk("R9", bok, 1, "random busy/ready");
        end
        finish_run();
    end
endmodule